// File: doc/BRIEF.md
# Interrupt Priority and Target Configuration Bank

This block is the register bank that an interrupt distributor keeps for its per-interrupt configuration. Every interrupt has an 8-bit priority byte. Every shared interrupt (ID 32 and up) also has an 8-bit byte that holds its CPU target mask. Four interrupts share one 32-bit word, one byte each. A small header holds three read-only words: a type word that describes the configuration, an implementer identity word and a peripheral identity word.

Software reaches the bank through two independent ports. The write port takes a word address, 32 data bits and four byte-lane strobes, so a single byte can be written. The read port takes a word address and the number of the CPU that is reading. It returns the data one cycle later. Each stored value is cut down to the bits the hardware holds: the upper PRIO_BITS bits of a priority and the low NUM_CPU bits of a target. Offsets past the implemented interrupt count behave as empty space.

The address map uses byte addresses, and the low two address bits are ignored. The header sits at 0x000 (type), 0x004 (implementer identity) and 0x008 (peripheral identity). The priority array starts at 0x400 and the target array at 0x800, and each array spans 1 KiB. Byte n of an array belongs to interrupt n, in lane n mod 4. Any other address reads as zero.

Top module: `irqcfg_bank`

## Requirements
- R1: After reset, every priority and every shared target reads as zero, and rd_valid is low.
- R2: rd_valid is high exactly one cycle after rd_en, and rd_data then holds the contents from the cycle in which rd_en was high. A write to the same word in that cycle does not appear until a later read.
- R3: A priority byte reads back as the value written with its low 8-PRIO_BITS bits forced to zero. The same mask (0xF8 by default) applies in all four lanes.
- R4: A write changes only the bytes whose strobe bit is set. Strobe bit k covers data bits 8k+7:8k.
- R5: In a shared target byte, bits at position NUM_CPU and above read as zero whatever value was written to them.
- R6: A target byte for an interrupt below ID 32 reads as the one-hot mask 1<<rd_cpu, limited to implemented CPUs. Writes to these bytes are ignored.
- R7: In either array, a word whose index is NUM_IRQ/4 or higher reads as zero. Writing it changes no stored byte.
- R8: The type word holds NUM_IRQ/32-1 in bits 4:0 and NUM_CPU-1 in bits 7:5, with all other bits zero (0x61 by default). The type word and both identity words keep their values after writes of 0xFFFFFFFF, 0xA5A55A5A and 0.
- R9: Header addresses other than the three defined words, and addresses at 0xC00 and above, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 12 | Write byte address (bits 1:0 ignored) |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte-lane write strobes |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read byte address (bits 1:0 ignored) |
| rd_cpu | input | 3 | Number of the CPU doing the read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |

## Verification
A read and a write can land in the same cycle, and they can target the same word. The bench makes this happen on purpose by driving both ports together on the same priority word and on the same target word, with partial strobes. It expects the response to carry the bytes as they were before the write. A second read must then show the merged result, masked as required. The random phase also issues reads and writes together on random addresses, so collisions occur there as well, and it checks every response against a model that applies each write only after the read in the same cycle.

// File: rtl/irqcfg_pkg.sv
package irqcfg_pkg;

    typedef enum logic [2:0] {
        RG_TYPE,
        RG_IMPL,
        RG_PERIPH,
        RG_PRIO,
        RG_TARGET,
        RG_NONE
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [7:0] word;
        logic       in_range;
    } decode_t;

    // Mask keeping the upper 'bits' bits of a priority byte.
    function automatic logic [7:0] prio_byte_mask(input int bits);
        logic [7:0] m;
        m = 8'hFF;
        m = m << (8 - bits);
        return m;
    endfunction

    // Mask keeping the bits of the CPUs that exist.
    function automatic logic [7:0] cpu_byte_mask(input int n);
        logic [8:0] t;
        t = (9'd1 << n) - 9'd1;
        return t[7:0];
    endfunction

    function automatic logic [31:0] lanes4(input logic [7:0] b);
        return {4{b}};
    endfunction

endpackage

// File: rtl/irqcfg_decode.sv
module irqcfg_decode
    import irqcfg_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [11:0] addr,
    output decode_t     dec
);
    localparam logic [8:0] WORD_LIMIT = 9'(NUM_IRQ / 4);

    always_comb begin
        dec.word     = addr[9:2];
        dec.in_range = ({1'b0, addr[9:2]} < WORD_LIMIT);
        unique case (addr[11:10])
            2'b00: begin
                if (addr[9:2] == 8'd0)      dec.region = RG_TYPE;
                else if (addr[9:2] == 8'd1) dec.region = RG_IMPL;
                else if (addr[9:2] == 8'd2) dec.region = RG_PERIPH;
                else                        dec.region = RG_NONE;
            end
            2'b01:   dec.region = RG_PRIO;
            2'b10:   dec.region = RG_TARGET;
            default: dec.region = RG_NONE;
        endcase
    end
endmodule

// File: rtl/irqcfg_prio_bank.sv
module irqcfg_prio_bank #(
    parameter int NUM_IRQ   = 64,
    parameter int PRIO_BITS = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_word,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_strb,
    input  logic [7:0]  rd_word,
    output logic [31:0] rd_data
);
    localparam int FLAT_W = NUM_IRQ * 8;

    logic [FLAT_W-1:0] prio_flat;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        localparam int         LANE = i % 4;
        localparam logic [7:0] WORD = 8'(i / 4);
        logic [PRIO_BITS-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_word == WORD) && wr_strb[LANE]) begin
                q <= wr_data[8*LANE+7 -: PRIO_BITS];
            end
        end

        if (PRIO_BITS == 8) begin : g_full
            assign prio_flat[8*i +: 8] = q;
        end else begin : g_part
            assign prio_flat[8*i +: 8] = {q, {(8-PRIO_BITS){1'b0}}};
        end
    end

    logic [12:0] rd_base;
    always_comb begin
        rd_base = {rd_word, 5'd0};
        rd_data = '0;
        for (int w = 0; w < NUM_IRQ / 4; w++) begin
            if (rd_word == 8'(w)) rd_data = prio_flat[32*w +: 32];
        end
    end

    logic unused_base;
    assign unused_base = ^rd_base;
endmodule

// File: rtl/irqcfg_target_bank.sv
module irqcfg_target_bank
    import irqcfg_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_word,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_strb,
    input  logic [7:0]  rd_word,
    input  logic [2:0]  rd_cpu,
    output logic [31:0] rd_data
);
    localparam int         FIRST_SHARED = 32;
    localparam int         FLAT_W       = NUM_IRQ * 8;
    localparam logic [7:0] CPU_MASK     = cpu_byte_mask(NUM_CPU);

    logic [FLAT_W-1:0] tgt_flat;
    logic [7:0]        self_mask;

    assign self_mask = (8'd1 << rd_cpu) & CPU_MASK;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_tgt
        if (i < FIRST_SHARED) begin : g_private
            assign tgt_flat[8*i +: 8] = self_mask;
        end else begin : g_shared
            localparam int         LANE = i % 4;
            localparam logic [7:0] WORD = 8'(i / 4);
            logic [NUM_CPU-1:0] q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_en && (wr_word == WORD) && wr_strb[LANE]) begin
                    q <= wr_data[8*LANE +: NUM_CPU];
                end
            end

            if (NUM_CPU == 8) begin : g_full
                assign tgt_flat[8*i +: 8] = q;
            end else begin : g_part
                assign tgt_flat[8*i +: 8] = {{(8-NUM_CPU){1'b0}}, q};
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_IRQ / 4; w++) begin
            if (rd_word == 8'(w)) rd_data = tgt_flat[32*w +: 32];
        end
    end
endmodule

// File: rtl/irqcfg_bank.sv
module irqcfg_bank
    import irqcfg_pkg::*;
#(
    parameter int          NUM_IRQ   = 64,
    parameter int          NUM_CPU   = 4,
    parameter int          PRIO_BITS = 5,
    parameter logic [31:0] IMPL_ID   = 32'h0102_0A5C,
    parameter logic [31:0] PERIPH_ID = 32'h0000_0024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [11:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_strb,
    input  logic        rd_en,
    input  logic [11:0] rd_addr,
    input  logic [2:0]  rd_cpu,
    output logic        rd_valid,
    output logic [31:0] rd_data
);
    localparam logic [31:0] TYPE_VAL =
        {24'd0, 3'(NUM_CPU - 1), 5'(NUM_IRQ / 32 - 1)};

    decode_t wdec, rdec;
    logic    prio_we, tgt_we;
    logic [31:0] prio_rd, tgt_rd, rd_next;

    irqcfg_decode #(.NUM_IRQ(NUM_IRQ)) u_wdec (.addr(wr_addr), .dec(wdec));
    irqcfg_decode #(.NUM_IRQ(NUM_IRQ)) u_rdec (.addr(rd_addr), .dec(rdec));

    assign prio_we = wr_en && (wdec.region == RG_PRIO)   && wdec.in_range;
    assign tgt_we  = wr_en && (wdec.region == RG_TARGET) && wdec.in_range;

    irqcfg_prio_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_prio (
        .clk(clk), .rst(rst), .wr_en(prio_we), .wr_word(wdec.word),
        .wr_data(wr_data), .wr_strb(wr_strb), .rd_word(rdec.word),
        .rd_data(prio_rd)
    );

    irqcfg_target_bank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_tgt (
        .clk(clk), .rst(rst), .wr_en(tgt_we), .wr_word(wdec.word),
        .wr_data(wr_data), .wr_strb(wr_strb), .rd_word(rdec.word),
        .rd_cpu(rd_cpu), .rd_data(tgt_rd)
    );

    always_comb begin
        unique case (rdec.region)
            RG_TYPE:   rd_next = TYPE_VAL;
            RG_IMPL:   rd_next = IMPL_ID;
            RG_PERIPH: rd_next = PERIPH_ID;
            RG_PRIO:   rd_next = rdec.in_range ? prio_rd : 32'd0;
            RG_TARGET: rd_next = rdec.in_range ? tgt_rd  : 32'd0;
            default:   rd_next = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/irqcfg_bank_chk.sv
module irqcfg_bank_chk
    import irqcfg_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int NUM_CPU   = 4,
    parameter int PRIO_BITS = 5
) (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic [11:0] rd_addr,
    input logic        rd_valid,
    input logic [31:0] rd_data
);
    localparam logic [31:0] PMASK4 = lanes4(prio_byte_mask(PRIO_BITS));
    localparam logic [31:0] CMASK4 = lanes4(cpu_byte_mask(NUM_CPU));
    localparam logic [8:0]  LIMIT  = 9'(NUM_IRQ / 4);

    logic is_prio, is_tgt, beyond, unmapped;
    assign is_prio  = (rd_addr[11:10] == 2'b01);
    assign is_tgt   = (rd_addr[11:10] == 2'b10);
    assign beyond   = (is_prio || is_tgt) && ({1'b0, rd_addr[9:2]} >= LIMIT);
    assign unmapped = (rd_addr[11:10] == 2'b11) ||
                      ((rd_addr[11:10] == 2'b00) && (rd_addr[9:2] > 8'd2));

    p_valid_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
    p_prio_low_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_prio) |=> ((rd_data & ~PMASK4) == 32'd0));
    p_target_cpu_bits_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_tgt) |=> ((rd_data & ~CMASK4) == 32'd0));
    p_beyond_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && beyond) |=> (rd_data == 32'd0));
    p_type_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr[11:2] == 10'd0) |=>
        (rd_data == {24'd0, 3'(NUM_CPU - 1), 5'(NUM_IRQ / 32 - 1)}));
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && unmapped) |=> (rd_data == 32'd0));
endmodule

bind irqcfg_bank irqcfg_bank_chk #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_BITS(PRIO_BITS)
) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/irqcfg_bank_tb_top.sv
module irqcfg_bank_tb_top;
    localparam int          NUM_IRQ   = 64;
    localparam int          NUM_CPU   = 4;
    localparam int          PRIO_BITS = 5;
    localparam logic [31:0] IMPL_ID   = 32'h0102_0A5C;
    localparam logic [31:0] PERIPH_ID = 32'h0000_0024;
    localparam logic [7:0]  PMASK     = 8'hF8;
    localparam logic [7:0]  CMASK     = 8'h0F;
    localparam logic [31:0] TYPE_EXP  = 32'h0000_0061;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_strb = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [2:0]  rd_cpu = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_prio [NUM_IRQ];
    logic [7:0] m_tgt  [NUM_IRQ];

    always #5 clk = ~clk;

    irqcfg_bank #(
        .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_BITS(PRIO_BITS),
        .IMPL_ID(IMPL_ID), .PERIPH_ID(PERIPH_ID)
    ) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_cpu(rd_cpu), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a,
                                               input logic [2:0] cpu);
        logic [31:0] r;
        int w;
        r = '0;
        w = int'(a[9:2]);
        case (a[11:10])
            2'b00: begin
                if (w == 0) r = TYPE_EXP;
                else if (w == 1) r = IMPL_ID;
                else if (w == 2) r = PERIPH_ID;
            end
            2'b01: if (w < NUM_IRQ / 4)
                for (int l = 0; l < 4; l++) r[8*l +: 8] = m_prio[4*w+l] & PMASK;
            2'b10: if (w < NUM_IRQ / 4)
                for (int l = 0; l < 4; l++)
                    r[8*l +: 8] = (4*w+l < 32) ? ((8'd1 << cpu) & CMASK)
                                               : (m_tgt[4*w+l] & CMASK);
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d,
                               input logic [3:0] s);
        int w;
        w = int'(a[9:2]);
        if (w >= NUM_IRQ / 4) return;
        for (int l = 0; l < 4; l++) begin
            if (s[l]) begin
                if (a[11:10] == 2'b01) m_prio[4*w+l] = d[8*l +: 8];
                if (a[11:10] == 2'b10 && 4*w+l >= 32) m_tgt[4*w+l] = d[8*l +: 8];
            end
        end
    endtask

    // Drive one cycle with optional write and optional read; returns read data.
    task automatic cycle(input logic we, input logic [11:0] wa, input logic [31:0] wd,
                         input logic [3:0] ws, input logic re, input logic [11:0] ra,
                         input logic [2:0] rc, output logic [31:0] rdat,
                         output logic [31:0] rexp, output logic rv);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; wr_strb = ws;
        rd_en = re; rd_addr = ra; rd_cpu = rc;
        rexp = model_read(ra, rc);
        if (we) model_write(wa, wd, ws);
        @(negedge clk);
        rdat = rd_data; rv = rd_valid;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] x, e; logic v;
        cycle(1'b1, a, d, s, 1'b0, 12'h0, 3'd0, x, e, v);
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [2:0] c, input string req);
        logic [31:0] x, e; logic v;
        cycle(1'b0, 12'h0, 32'h0, 4'h0, 1'b1, a, c, x, e, v);
        check(v === 1'b1, req, {31'd0, v}, 32'd1);
        check(x === e, req, x, e);
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog: actual=%08h expected=%08h", 0, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] x, e, pat;
        logic v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NUM_IRQ; i++) begin m_prio[i] = '0; m_tgt[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_valid === 1'b0, "R1", {31'd0, rd_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_valid === 1'b0, "R1", {31'd0, rd_valid}, 32'd0);
        rd_chk(12'h420, 3'd0, "R1");
        rd_chk(12'h83C, 3'd0, "R1");

        // R8: header words are fixed and ignore writes
        rd_chk(12'h000, 3'd0, "R8");
        check(model_read(12'h000, 0) == 32'h61, "R8", model_read(12'h000, 0), 32'h61);
        for (int p = 0; p < 3; p++) begin
            pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5A5_5A5A : 32'h0;
            for (int h = 0; h < 3; h++) begin
                wr(12'(4*h), pat, 4'hF);
                rd_chk(12'(4*h), 3'd1, "R8");
            end
        end

        // R3: priority masking in every lane
        wr(12'h420, 32'hFF7F_BF3F, 4'hF);
        rd_chk(12'h420, 3'd0, "R3");
        cycle(1'b0, 0, 0, 0, 1'b1, 12'h420, 0, x, e, v);
        check(x == 32'hF878_B838, "R3", x, 32'hF878_B838);
        wr(12'h420, 32'hFFFF_FFFF, 4'hF);
        rd_chk(12'h420, 3'd0, "R3");

        // R4: single-lane write
        wr(12'h420, 32'h001F_0000, 4'b0100);
        cycle(1'b0, 0, 0, 0, 1'b1, 12'h420, 0, x, e, v);
        check(x == 32'hF818_F8F8, "R4", x, 32'hF818_F8F8);

        // R5: target bits above NUM_CPU masked
        wr(12'h820, 32'h0103_020F, 4'hF);
        rd_chk(12'h820, 3'd0, "R5");
        wr(12'h824, 32'hFFFF_FFFF, 4'hF);
        cycle(1'b0, 0, 0, 0, 1'b1, 12'h824, 0, x, e, v);
        check(x == 32'h0F0F_0F0F, "R5", x, 32'h0F0F_0F0F);

        // R6: private target bytes
        for (int c = 0; c < 8; c++) rd_chk(12'h800, 3'(c), "R6");
        wr(12'h804, 32'hFFFF_FFFF, 4'hF);
        cycle(1'b0, 0, 0, 0, 1'b1, 12'h804, 3'd2, x, e, v);
        check(x == 32'h0404_0404, "R6", x, 32'h0404_0404);

        // R7: beyond implemented count
        wr(12'h410 + 12'(NUM_IRQ) - 12'h10, 32'h0, 4'hF);
        wr(12'h400 + 12'(NUM_IRQ), 32'hFFFF_FFFF, 4'hF);
        rd_chk(12'h400 + 12'(NUM_IRQ), 3'd0, "R7");
        rd_chk(12'h400 + 12'(NUM_IRQ) - 12'h4, 3'd0, "R7");
        wr(12'h800 + 12'(NUM_IRQ), 32'hFFFF_FFFF, 4'hF);
        rd_chk(12'h800 + 12'(NUM_IRQ), 3'd0, "R7");
        rd_chk(12'h800 + 12'(NUM_IRQ) - 12'h4, 3'd0, "R7");

        // R9: unmapped addresses
        rd_chk(12'h00C, 3'd0, "R9");
        rd_chk(12'hC00, 3'd0, "R9");
        rd_chk(12'hFFC, 3'd0, "R9");

        // R2: same-cycle read and write to one word returns old contents
        cycle(1'b1, 12'h430, 32'hAAAA_5555, 4'b0011, 1'b1, 12'h430, 0, x, e, v);
        check(x === e && v, "R2", x, e);
        rd_chk(12'h430, 3'd0, "R2");
        cycle(1'b1, 12'h838, 32'h0606_0606, 4'b1010, 1'b1, 12'h838, 0, x, e, v);
        check(x === e && v, "R2", x, e);
        rd_chk(12'h838, 3'd0, "R2");

        // Random mix (R2, R3, R4, R5, R6, R7)
        for (int n = 0; n < 600; n++) begin
            logic [11:0] wa, ra;
            logic [31:0] wd;
            logic [3:0]  ws;
            logic        we, re;
            wa = {($urandom % 4 == 0) ? 2'b00 : (($urandom % 2) ? 2'b01 : 2'b10),
                  8'($urandom % 24), 2'($urandom)};
            ra = ($urandom % 3 == 0) ? wa :
                 {2'($urandom % 3 + 1), 8'($urandom % 24), 2'b00};
            wd = $urandom; ws = 4'($urandom);
            we = 1'($urandom); re = ($urandom % 4 != 0);
            cycle(we, wa, wd, ws, re, ra, 3'($urandom), x, e, v);
            check(v === re, "R2", {31'd0, v}, {31'd0, re});
            if (re) check(x === e, "R4", x, e);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule